// File: doc/BRIEF.md
# Paged Write Cycle Controller

This block sits behind the serial protocol engine of a small serial non-volatile memory. While a write command is being received it gathers the data bytes into a one-page holding buffer. The word address sent with the command fixes the page. The low offset bits walk forward with each byte and wrap inside the page, so they never carry into the page number. The buffer is committed only when a stop condition follows at least one complete data byte. The commit sweeps the buffer once, issues one array write strobe for each offset that received data, and then holds the block busy for a timed internal write cycle. The cycle length is counted in pulses of a slow tick, so one cycle covers the whole page.

While busy, the block ignores every command strobe. The protocol engine uses the busy flag to withhold its acknowledge of the device address, which lets a master poll for completion. A write-protect input held high at a data byte, or at any time after the first data byte, drops the pending command. Raised during the cycle, it ends the cycle at once. A supply-low inhibit input also blocks any rewrite.

Top module: `page_commit_ctrl`

## Requirements
- R1: After reset, busy and arr_we are low.
- R2: A word address strobe sets the page from its upper ADDR_W-5 bits and the offset from its low 5 bits. Each data byte is stored at the current offset, after which the offset increments modulo 32 and the page bits are not touched. For example, a start at offset 0x1E continues at 0x1F, then 0x00, then 0x01. Every strobe of a commit carries the page bits in arr_addr[11:5] and the offset in arr_addr[4:0].
- R3: A stop that arrives before any data byte of the command starts nothing: busy stays low and no array strobe is issued.
- R4: When more than 32 bytes arrive, later bytes overwrite the buffer at their wrapped offsets. Each offset is strobed at most once per commit, in ascending offset order, with its last value.
- R5: Offsets that received no byte since the last start condition are not strobed, and arr_we is never high while busy is low.
- R6: busy rises on the clock after an accepted stop. It stays high until CYCLE_TICKS tick pulses have been counted after that stop and the buffer sweep is done, and then it falls.
- R7: While busy is high, start, address, data and stop strobes are ignored, so none of them can lead to a later commit.
- R8: wp high together with a data byte strobe, in any cycle after the first data byte, or at the stop drops the command: no strobe is issued and busy stays low.
- R9: wp high between the start condition and the first data byte has no effect on the write.
- R10: wp high while busy makes busy fall on the next clock, and no further array strobes follow.
- R11: lv_inhibit high at the stop prevents the commit. lv_inhibit high during a sweep suppresses the array strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | One-cycle pulse: start condition seen |
| waddr_vld | input | 1 | One-cycle pulse: word address received |
| waddr | input | ADDR_W | Received word address |
| wbyte_vld | input | 1 | One-cycle pulse: data byte complete (D0 sampled) |
| wbyte | input | DATA_W | Received data byte |
| cmd_stop | input | 1 | One-cycle pulse: stop condition seen |
| wp | input | 1 | Write protect, high blocks or cancels rewriting |
| lv_inhibit | input | 1 | Supply-low inhibit, high blocks rewriting |
| tick | input | 1 | Slow time-base pulse used to time the write cycle |
| busy | output | 1 | Internal write cycle in progress; address must not be acknowledged |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array byte address for arr_we |
| arr_data | output | DATA_W | Array write data for arr_we |

## Verification
The bench builds the block with the default 12-bit address, 8-bit data and 32-byte page, and shortens the write cycle to CYCLE_TICKS = 4. It also drives the tick input itself. The short cycle puts the exact tick that ends busy within reach, so that boundary is checked tick by tick. The full page size exercises the real wrap from offset 0x1F to 0x00 and the overrun beyond 32 bytes. Cancellation is checked part way through the buffer sweep, where a partial commit is still observable.

// File: rtl/pcw_pkg.sv
// Package: shared types for the paged write cycle controller.
// Assumes: nothing beyond IEEE 1800-2017.
package pcw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // collecting a command, array untouched
        ST_SWEEP = 2'd1,   // walking the page buffer, issuing strobes
        ST_WAIT  = 2'd2    // waiting for the timed cycle to elapse
    } wst_t;
endpackage

// File: rtl/page_buffer.sv
// page_buffer: one page of byte storage with a per-offset written flag.
// Assumes PAGE_BYTES is a power of two; clr and wr_en never coincide.
module page_buffer #(
    parameter int PAGE_BYTES = 32,
    parameter int DATA_W     = 8,
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_vld
);
    logic [PAGE_BYTES-1:0] vld_q;
    logic [DATA_W-1:0]     mem_q [PAGE_BYTES];

    // Track which offsets hold data for the current command.
    always_ff @(posedge clk) begin
        if (!rst_n)     vld_q <= '0;
        else if (clr)   vld_q <= '0;
        else if (wr_en) vld_q[wr_off] <= 1'b1;
    end

    // Store the byte; a repeated offset simply overwrites.
    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_off] <= wr_data;
    end

    // Combinational read port for the commit sweep.
    always_comb begin
        rd_data = mem_q[rd_off];
        rd_vld  = vld_q[rd_off];
    end

    // R5: a clear leaves no offset marked as written.
    a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (vld_q == '0));
endmodule

// File: rtl/tick_timer.sv
// tick_timer: counts slow tick pulses after launch; expired stays high
// once CYCLE_TICKS pulses are counted, until halted or relaunched.
// Assumes CYCLE_TICKS >= 1.
module tick_timer #(
    parameter int CYCLE_TICKS = 5,
    localparam int CNT_W      = $clog2(CYCLE_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic halt,
    input  logic tick,
    output logic expired
);
    logic             run_q;
    logic [CNT_W-1:0] cnt_q;

    // Run flag and saturating tick count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (launch) begin
            run_q <= 1'b1;
            cnt_q <= '0;
        end else if (halt) begin
            run_q <= 1'b0;
        end else if (run_q && tick && (cnt_q != CNT_W'(CYCLE_TICKS))) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Cycle has elapsed.
    assign expired = run_q && (cnt_q == CNT_W'(CYCLE_TICKS));

    // R6: a freshly launched cycle is never already over.
    a_r6_no_early_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> !expired);
    // R6: without a tick the count does not move.
    a_r6_count_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !tick && !launch) |=> $stable(cnt_q));
endmodule

// File: rtl/page_commit_ctrl.sv
// page_commit_ctrl: gathers the data bytes of one write command into a
// page buffer, commits them on stop, and times the internal write cycle.
// Assumes single-cycle event strobes from the protocol engine, wp and
// lv_inhibit already synchronised, PAGE_BYTES a power of two.
module page_commit_ctrl
    import pcw_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 8,
    parameter int PAGE_BYTES  = 32,
    parameter int CYCLE_TICKS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              waddr_vld,
    input  logic [ADDR_W-1:0] waddr,
    input  logic              wbyte_vld,
    input  logic [DATA_W-1:0] wbyte,
    input  logic              cmd_stop,
    input  logic              wp,
    input  logic              lv_inhibit,
    input  logic              tick,
    output logic              busy,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_data
);
    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - OFF_W;

    wst_t              state_q;
    logic [PAGE_W-1:0] page_q;
    logic [OFF_W-1:0]  off_q;
    logic [OFF_W-1:0]  sweep_q;
    logic              have_q;
    logic              drop_q;
    logic              idle;
    logic              accept;
    logic              halt;
    logic              expired;
    logic [DATA_W-1:0] rd_data;
    logic              rd_vld;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    // Decode: accept a stop only after a clean, complete data byte.
    always_comb begin
        idle   = (state_q == ST_IDLE);
        accept = idle && cmd_stop && have_q && !drop_q && !wp && !lv_inhibit;
        halt   = !idle && (wp || ((state_q == ST_WAIT) && expired));
    end

    page_buffer #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (idle && cmd_start),
        .wr_en   (idle && wbyte_vld),
        .wr_off  (off_q),
        .wr_data (wbyte),
        .rd_off  (sweep_q),
        .rd_data (rd_data),
        .rd_vld  (rd_vld)
    );

    tick_timer #(.CYCLE_TICKS(CYCLE_TICKS)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (accept),
        .halt    (halt),
        .tick    (tick),
        .expired (expired)
    );

    // Command collection: page, wrapping offset, data seen, protect drop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
            off_q  <= '0;
            have_q <= 1'b0;
            drop_q <= 1'b0;
        end else if (idle) begin
            if (cmd_start || cmd_stop) begin
                have_q <= 1'b0;
                drop_q <= 1'b0;
            end else begin
                if (waddr_vld) begin
                    page_q <= waddr[ADDR_W-1:OFF_W];
                    off_q  <= waddr[OFF_W-1:0];
                end
                if (wbyte_vld) begin
                    off_q  <= off_q + 1'b1;
                    have_q <= 1'b1;
                end
                if ((wbyte_vld || have_q) && wp) drop_q <= 1'b1;
            end
        end
    end

    // Cycle sequencing: sweep the buffer, then wait out the timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sweep_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    state_q <= ST_SWEEP;
                    sweep_q <= '0;
                end
                ST_SWEEP: if (wp) begin
                    state_q <= ST_IDLE;
                end else begin
                    sweep_q <= sweep_q + 1'b1;
                    if (sweep_q == OFF_W'(PAGE_BYTES - 1)) state_q <= ST_WAIT;
                end
                ST_WAIT: if (wp || expired) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Registered array write port, gated by protect and supply inhibit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q   <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            we_q   <= (state_q == ST_SWEEP) && rd_vld && !wp && !lv_inhibit;
            addr_q <= {page_q, sweep_q};
            data_q <= rd_data;
        end
    end

    assign busy     = !idle;
    assign arr_we   = we_q;
    assign arr_addr = addr_q;
    assign arr_data = data_q;

    // R10: protect raised during the cycle ends it on the next clock.
    a_r10_wp_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wp) |=> !busy);
    // R5: no array strobe outside a commit.
    a_r5_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !arr_we);
    // R11: supply inhibit suppresses array strobes.
    a_r11_inhibit_gates: assert property (@(posedge clk) disable iff (!rst_n)
        lv_inhibit |=> !arr_we);
    // R4: back-to-back strobes walk offsets strictly upward.
    a_r4_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && $past(arr_we)) |-> (arr_addr[OFF_W-1:0] > $past(arr_addr[OFF_W-1:0])));
    // R7: the page cannot be changed by commands while busy.
    a_r7_page_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(page_q));
endmodule

// File: tb/sim_page_commit_ctrl.sv
module sim_page_commit_ctrl;
    localparam int CT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_start = 0, waddr_vld = 0, wbyte_vld = 0, cmd_stop = 0;
    logic       wp = 0, lv_inhibit = 0, tick = 0;
    logic [11:0] waddr = '0;
    logic [7:0]  wbyte = '0;
    logic        busy, arr_we;
    logic [11:0] arr_addr;
    logic [7:0]  arr_data;

    int nchecks = 0;
    int nfail   = 0;
    int nstrobe = 0;
    int cyc     = 0;
    logic [7:0] cap_d [32];
    logic       cap_hit [32];
    logic [6:0] cap_hi;
    logic [7:0] exp_d [32];
    logic       exp_hit [32];

    // Vector fields: {start address[11:0], byte count[6:0], first value[7:0]}.
    localparam logic [26:0] VEC [4] = '{
        {12'h01E, 7'd4,  8'h10},   // R2 wrap 1E,1F,00,01
        {12'h7A0, 7'd1,  8'h55},   // single byte
        {12'hFE0, 7'd32, 8'h80},   // full page
        {12'h345, 7'd40, 8'hC0}    // R4 overrun
    };

    page_commit_ctrl #(.CYCLE_TICKS(CT)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .waddr_vld(waddr_vld),
        .waddr(waddr), .wbyte_vld(wbyte_vld), .wbyte(wbyte), .cmd_stop(cmd_stop),
        .wp(wp), .lv_inhibit(lv_inhibit), .tick(tick), .busy(busy),
        .arr_we(arr_we), .arr_addr(arr_addr), .arr_data(arr_data)
    );

    always #4 clk = ~clk;

    // Capture array strobes away from the active edge.
    always @(negedge clk) begin
        if (arr_we) begin
            cap_d[arr_addr[4:0]]   = arr_data;
            cap_hit[arr_addr[4:0]] = 1'b1;
            cap_hi                 = arr_addr[11:5];
            nstrobe++;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nfail++;
            $display("FAIL R6 watchdog actual=%0d expected<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(); @(negedge clk); endtask
    task automatic s_start(); cmd_start = 1; step(); cmd_start = 0; endtask
    task automatic s_stop();  cmd_stop = 1;  step(); cmd_stop = 0;  endtask
    task automatic s_addr(input logic [11:0] a); waddr = a; waddr_vld = 1; step(); waddr_vld = 0; endtask
    task automatic s_byte(input logic [7:0] d);  wbyte = d; wbyte_vld = 1; step(); wbyte_vld = 0; endtask
    task automatic p_tick(); tick = 1; step(); tick = 0; step(); endtask

    task automatic clr_cap();
        for (int i = 0; i < 32; i++) begin cap_hit[i] = 0; cap_d[i] = '0; end
        nstrobe = 0;
    endtask

    task automatic finish_cycle();
        repeat (40) step();
        repeat (CT) p_tick();
        repeat (2) step();
    endtask

    task automatic write_cmd(input logic [11:0] a, input int n, input logic [7:0] seed);
        s_start();
        s_addr(a);
        for (int i = 0; i < n; i++) s_byte(seed + 8'(i));
    endtask

    initial begin
        int sn;
        clr_cap();
        repeat (3) step();
        chk("R1 busy after reset", 32'(busy), 0);
        chk("R1 arr_we after reset", 32'(arr_we), 0);
        rst_n = 1;
        step();

        // Table walk: R2 R4 R5 page contents.
        for (int v = 0; v < 4; v++) begin
            logic [11:0] a;
            int          n;
            logic [7:0]  sd;
            a = VEC[v][26:15]; n = int'(VEC[v][14:8]); sd = VEC[v][7:0];
            for (int i = 0; i < 32; i++) begin exp_hit[i] = 0; exp_d[i] = '0; end
            for (int i = 0; i < n; i++) begin
                exp_d[(int'(a[4:0]) + i) % 32]   = sd + 8'(i);
                exp_hit[(int'(a[4:0]) + i) % 32] = 1'b1;
            end
            clr_cap();
            write_cmd(a, n, sd);
            s_stop();
            finish_cycle();
            chk("R4 strobe count", 32'(nstrobe), 32'((n > 32) ? 32 : n));
            chk("R2 page bits", 32'(cap_hi), 32'(a[11:5]));
            for (int i = 0; i < 32; i++) begin
                chk("R5 offset written", 32'(cap_hit[i]), 32'(exp_hit[i]));
                if (exp_hit[i]) chk("R2 R4 offset data", 32'(cap_d[i]), 32'(exp_d[i]));
            end
            chk("R6 idle after cycle", 32'(busy), 0);
        end

        // R3: stop after address only.
        clr_cap();
        s_start(); s_addr(12'h120); s_stop();
        chk("R3 no busy without data", 32'(busy), 0);
        repeat (40) step();
        chk("R3 no strobes without data", 32'(nstrobe), 0);

        // R6: busy timing by ticks.
        clr_cap();
        write_cmd(12'h200, 2, 8'h31);
        s_stop();
        chk("R6 busy next clock", 32'(busy), 1);
        repeat (40) step();
        repeat (CT - 1) p_tick();
        step();
        chk("R6 busy before last tick", 32'(busy), 1);
        p_tick(); step(); step();
        chk("R6 idle after last tick", 32'(busy), 0);
        chk("R6 strobes", 32'(nstrobe), 2);

        // R7: commands while busy are ignored.
        clr_cap();
        write_cmd(12'h400, 1, 8'h77);
        s_stop();
        write_cmd(12'h500, 3, 8'hAA);
        finish_cycle();
        sn = nstrobe;
        s_stop();
        chk("R7 late stop no busy", 32'(busy), 0);
        repeat (40) step();
        chk("R7 no commit from busy-time bytes", 32'(nstrobe), 32'(sn));
        chk("R7 first commit page", 32'(cap_hi), 32'(7'h20));

        // R8: wp with a data byte.
        clr_cap();
        s_start(); s_addr(12'h600); s_byte(8'h01);
        wp = 1; s_byte(8'h02); wp = 0;
        s_stop();
        repeat (40) step();
        chk("R8 wp at byte busy", 32'(busy), 0);
        chk("R8 wp at byte strobes", 32'(nstrobe), 0);

        // R8: wp pulse between bytes and stop.
        clr_cap();
        write_cmd(12'h610, 2, 8'h05);
        wp = 1; step(); wp = 0; step();
        s_stop();
        repeat (40) step();
        chk("R8 wp after data strobes", 32'(nstrobe), 0);

        // R8: wp at the stop.
        clr_cap();
        write_cmd(12'h620, 2, 8'h09);
        wp = 1; s_stop(); wp = 0;
        repeat (40) step();
        chk("R8 wp at stop strobes", 32'(nstrobe), 0);

        // R9: wp before first data byte is don't care.
        clr_cap();
        wp = 1; s_start(); s_addr(12'h640); wp = 0;
        s_byte(8'h4C);
        s_stop();
        finish_cycle();
        chk("R9 write done", 32'(nstrobe), 1);
        chk("R9 data", 32'(cap_d[0]), 32'h4C);

        // R10: cancel mid sweep.
        clr_cap();
        write_cmd(12'h700, 32, 8'h00);
        s_stop();
        repeat (5) step();
        wp = 1; step();
        chk("R10 busy drops", 32'(busy), 0);
        wp = 0;
        sn = nstrobe;
        repeat (40) step();
        chk("R10 partial commit", 32'(sn < 32), 1);
        chk("R10 no strobes after cancel", 32'(nstrobe), 32'(sn));

        // R11: inhibit at stop.
        clr_cap();
        write_cmd(12'h800, 3, 8'h21);
        lv_inhibit = 1; s_stop(); lv_inhibit = 0;
        repeat (40) step();
        chk("R11 inhibit busy", 32'(busy), 0);
        chk("R11 inhibit strobes", 32'(nstrobe), 0);

        // R11: inhibit during sweep.
        clr_cap();
        write_cmd(12'h820, 3, 8'h21);
        s_stop();
        lv_inhibit = 1;
        repeat (40) step();
        lv_inhibit = 0;
        repeat (CT) p_tick();
        repeat (2) step();
        chk("R11 inhibit during sweep strobes", 32'(nstrobe), 0);

        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end
endmodule